// File: doc/BRIEF.md
# Per-Slot Level Ramp Unit

This block keeps an attenuation level for each of 32 time-multiplexed operator slots and moves it toward a programmed target. The slots form 8 channels, and slot s belongs to channel s mod 8. A free-running 5-bit cycle number visits one slot per clock. In each visit the block receives that slot's 8-bit target word and that channel's 8-bit divider.

Bit 7 of the target word selects the mode. When the bit is clear, the level is loaded at once with the low 7 bits times eight. When the bit is set, the level moves by one unit at a time toward the target. Each channel has a counter that sets how often it moves: the counter advances once per 32-cycle frame and allows a move when it equals the channel's divider.

The level of the slot visited two cycles earlier is registered. It is added without a shift to an incoming envelope attenuation, and the sum saturates at the 10-bit maximum. An initial-clear input zeroes the counter and the level of each slot and channel it visits.

Top module: `level_slew`

## Requirements
- R1: A channel counter may advance only in a clock whose value ((cycle+1) mod 32) is less than 8. The slot visited in a clock is the cycle value, and its channel is the cycle value mod 8. Each counter therefore advances once per 32-cycle frame.
- R2: A channel matches when its divider equals its counter. On a step clock with a match, the counter returns to 0; otherwise it adds the step enable. A ramping slot whose divider is D changes level once every D+1 frames, that is every 32*(D+1) cycles.
- R3: When bit 7 of a slot's target word is set and its channel matches, the level moves by exactly 1. It moves up if (level >> 3) is below the 7-bit target and down if it is above.
- R4: When bit 7 of the target word is clear, the visit loads the level with the 7-bit target shifted left by 3.
- R5: After the clock edge at cycle c, lvl_tap holds the level of slot (c+30) mod 32.
- R6: att_sum is env_att plus lvl_tap with no shift. If the sum reaches 1024 or more, att_sum is 1023.
- R7: While init_clr is high, each visit zeroes its channel counter and its slot level. After init_clr has been held for a full frame, lvl_tap reads 0 and att_sum equals env_att.
- R8: A ramping slot settles and then holds. Ramping up, it stops at 8*target. Ramping down, it stops at 8*target+7. It holds that level for as long as the target word stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| init_clr | input | 1 | Initial clear; zeroes the counter and level of the visited channel and slot |
| cycle | input | 5 | Slot number visited in this clock |
| tl_in | input | 8 | Target word of the visited slot; bit 7 set selects ramp mode |
| div_in | input | 8 | Ramp divider of the visited channel |
| env_att | input | 10 | Envelope attenuation to which the level is added |
| lvl_tap | output | 10 | Level of the slot visited two cycles back |
| att_sum | output | 10 | Saturated sum of env_att and lvl_tap |

## Verification
Two events meet in one clock: a channel's counter wrapping on a step-and-match, and the level move of the slot visited in that same clock. Slot 5 is the step slot of channel 5, so a ramp on slot 5 with divider values 0, 1 and 5 provokes this collision in every period. The result is judged by the level changes of slot 5. They must keep an exact spacing of D+1 frames, each must move by one unit in the right direction, and the level must settle at the asymmetric end value and stay there.

// File: rtl/level_slew.sv
module level_slew #(
  parameter int SLOTS    = 32,
  parameter int CHANS    = 8,
  parameter int CW       = 5,
  parameter int LW       = 10,
  parameter int TW       = 8,
  parameter int DW       = 8,
  parameter int STEP_WIN = 8,
  parameter int RD_LAG   = 2
) (
  input  logic          clk,
  input  logic          init_clr,
  input  logic [CW-1:0] cycle,
  input  logic [TW-1:0] tl_in,
  input  logic [DW-1:0] div_in,
  input  logic [LW-1:0] env_att,
  output logic [LW-1:0] lvl_tap,
  output logic [LW-1:0] att_sum
);
  localparam int CHW = $clog2(CHANS);
  localparam int SHIFT = LW - (TW - 1);
  localparam logic [CW-1:0] WIN = CW'(STEP_WIN);
  localparam logic [CW-1:0] LAG = CW'(RD_LAG);

  logic [LW-1:0] lvl [SLOTS];
  logic [DW-1:0] cnt [CHANS];

  wire [CHW-1:0]  ch     = cycle[CHW-1:0];
  wire [CW-1:0]   cyc_nx = cycle + 1'b1;
  wire            step   = cyc_nx < WIN;
  wire            match  = div_in == cnt[ch];
  wire            ramp   = tl_in[TW-1];
  wire [TW-2:0]   tgt    = tl_in[TW-2:0];
  wire [LW-1:0]   cur    = lvl[cycle];
  wire [TW-2:0]   cur_hi = cur[LW-1:SHIFT];
  wire [CW-1:0]   rd     = cycle - LAG;
  wire [LW:0]     sum_w  = {1'b0, env_att} + {1'b0, lvl_tap};

  always_ff @(posedge clk) begin
    if (init_clr) begin
      cnt[ch]    <= '0;
      lvl[cycle] <= '0;
    end else begin
      if (step && match) cnt[ch] <= '0;
      else               cnt[ch] <= cnt[ch] + DW'(step);
      if (!ramp)
        lvl[cycle] <= {tgt, {SHIFT{1'b0}}};
      else if (match) begin
        if (cur_hi < tgt)      lvl[cycle] <= cur + 1'b1;
        else if (cur_hi > tgt) lvl[cycle] <= cur - 1'b1;
      end
    end
    lvl_tap <= lvl[rd];
  end

  assign att_sum = sum_w[LW] ? {LW{1'b1}} : sum_w[LW-1:0];
endmodule

// File: rtl/level_slew_chk.sv
module level_slew_chk (
  input logic       clk,
  input logic       init_clr,
  input logic [7:0] tl_in,
  input logic [9:0] env_att,
  input logic [9:0] lvl_tap,
  input logic [9:0] att_sum
);
  logic [5:0] since;

  always_ff @(posedge clk) begin
    if (init_clr) since <= '0;
    else if (since != 6'd63) since <= since + 6'd1;
  end

  // R6
  sum_floor_chk: assert property (@(posedge clk) disable iff (init_clr)
    (since >= 6'd2) |-> (att_sum >= env_att && att_sum >= lvl_tap));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (init_clr)
    (since >= 6'd4 && !$past(tl_in[7], 3))
      |-> lvl_tap == {$past(tl_in[6:0], 3), 3'b000});

  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (init_clr)
    (since >= 6'd40 && $past(tl_in[7], 3) && $past(tl_in, 3) == $past(tl_in, 35))
      |-> (lvl_tap == $past(lvl_tap, 32) || lvl_tap == $past(lvl_tap, 32) + 10'd1
           || lvl_tap + 10'd1 == $past(lvl_tap, 32)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (init_clr)
    (since >= 6'd40 && $past(tl_in[7], 3) && $past(tl_in, 3) == $past(tl_in, 35)
      && $past(lvl_tap[9:3], 32) == $past(tl_in[6:0], 3))
      |-> lvl_tap == $past(lvl_tap, 32));
endmodule

bind level_slew level_slew_chk u_chk (
  .clk(clk), .init_clr(init_clr), .tl_in(tl_in),
  .env_att(env_att), .lvl_tap(lvl_tap), .att_sum(att_sum)
);

// File: tb/level_slew_bench.sv
`timescale 1ns/1ps
module level_slew_bench;
  logic       clk = 1'b0;
  logic       init_clr = 1'b1;
  logic [4:0] cyc = '0;
  logic [7:0] tl_reg [32];
  logic [7:0] div_reg [8];
  logic [9:0] env = '0;
  logic [9:0] lvl_tap, att_sum;
  logic [7:0] tl_in, div_in;
  int errors = 0, checks = 0;
  bit done = 0;

  assign tl_in  = tl_reg[cyc];
  assign div_in = div_reg[cyc[2:0]];

  always #2.5 clk = ~clk;

  level_slew u_level_slew (
    .clk(clk), .init_clr(init_clr), .cycle(cyc), .tl_in(tl_in),
    .div_in(div_in), .env_att(env), .lvl_tap(lvl_tap), .att_sum(att_sum)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #1;
    cyc = cyc + 5'd1;
  endtask

  task automatic frame_sample(output int v);
    do adv(); while (cyc != 5'd8);
    v = lvl_tap;
  endtask

  task automatic do_init();
    init_clr = 1'b1;
    for (int i = 0; i < 32; i++) tl_reg[i] = 8'h00;
    for (int i = 0; i < 8; i++) div_reg[i] = 8'h00;
    repeat (40) adv();
    init_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_init();
    env = 10'd37;
    repeat (2) adv();
    for (int i = 0; i < 8; i++) begin
      adv();
      chk(lvl_tap == 10'd0, "R7 level after clear", lvl_tap, 0);
      chk(att_sum == 10'd37, "R7 sum after clear", att_sum, 37);
    end
  endtask

  task automatic t_tap();
    do_init();
    env = 10'd0;
    for (int i = 0; i < 32; i++) tl_reg[i] = 8'(i);
    repeat (40) adv();
    for (int i = 0; i < 32; i++) begin
      int e;
      adv();
      e = ((int'(cyc) + 29) % 32) * 8;
      chk(lvl_tap == 10'(e), "R5 R4 tap slot", lvl_tap, e);
      chk(att_sum == 10'(e), "R6 unshifted sum", att_sum, e);
    end
  endtask

  task automatic t_sat();
    do_init();
    for (int i = 0; i < 32; i++) tl_reg[i] = 8'h7F;
    env = 10'd7;
    repeat (40) adv();
    chk(att_sum == 10'd1023, "R6 sum exactly 1023", att_sum, 1023);
    env = 10'd8;
    adv();
    chk(att_sum == 10'd1023, "R6 saturate at 1024", att_sum, 1023);
    env = 10'd1000;
    adv();
    chk(att_sum == 10'd1023, "R6 saturate large", att_sum, 1023);
    for (int i = 0; i < 32; i++) tl_reg[i] = 8'h10;
    env = 10'd200;
    repeat (40) adv();
    chk(att_sum == 10'd328, "R6 plain sum", att_sum, 328);
  endtask

  task automatic t_ramp(input int d, input int start, input int tgt, input int fin);
    int prev, v, gap, nchg, nfr, dir;
    do_init();
    env = 10'd0;
    div_reg[5] = 8'(d);
    tl_reg[5] = 8'(start);
    frame_sample(v);
    frame_sample(v);
    chk(v == start * 8, "R4 preload", v, start * 8);
    dir = (fin > start * 8) ? 1 : -1;
    tl_reg[5] = 8'h80 | 8'(tgt);
    frame_sample(prev);
    nfr = ((fin > start * 8 ? fin - start * 8 : start * 8 - fin) + 2) * (d + 1) + 4;
    gap = 0;
    nchg = 0;
    for (int f = 0; f < nfr; f++) begin
      frame_sample(v);
      gap++;
      if (v != prev) begin
        chk(v - prev == dir, "R3 unit step", v - prev, dir);
        if (nchg > 0) chk(gap == d + 1, "R1 R2 step period frames", gap, d + 1);
        nchg++;
        gap = 0;
        prev = v;
      end
    end
    chk(v == fin, "R8 settled level", v, fin);
    for (int f = 0; f < 3 * (d + 1) + 2; f++) begin
      frame_sample(v);
      chk(v == fin, "R8 holds at target", v, fin);
    end
  endtask

  initial begin
    t_reset();
    t_tap();
    t_sat();
    t_ramp(0, 2, 4, 32);
    t_ramp(1, 16, 12, 103);
    t_ramp(5, 3, 6, 48);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule